// File: doc/BRIEF.md
# Clock Synchronizer Mode Controller

This block sets the operating mode of a digital phase-locked loop that recovers network timing. It runs six modes. Free-run, locked and holdover are the lasting ones. Pre-locked, pre-locked-2 and lost-phase are passing stages. The controller moves between them on a small set of status inputs: a strobe saying a reference was chosen, the loop's phase-lock indicator, a disqualify flag from the leaky-bucket anomaly counter, and a flag saying a good standby reference exists. All waiting is measured in one-second ticks. The ticks come from a shared timebase, not from the system clock.

The outputs tell the loop and the reference selector what to do. A freeze strobe tells the loop to hold its present frequency. A disqualify pulse and a new-reference request go to the selector. A phase-alarm flag reports a reference that stayed out of lock too long. A forced-control input lets an external agent write the mode code directly. That path is used for testing and for hands-on operation.

Top module: `clksync_mode_ctrl`

## Requirements
- R1: After a synchronous reset, `mode_o` is 0 (free-run), control is automatic, and `freeze_o`, `disq_o`, `new_ref_req_o` and `phase_alarm_o` are all 0. Mode codes are 0 free-run, 1 pre-locked, 2 locked, 3 lost-phase, 4 pre-locked-2 and 5 holdover. `mode_o` never shows 6 or 7.
- R2: In free-run, a `ref_sel_i` strobe moves the mode to pre-locked one clock after the strobe is sampled.
- R3: Lock is qualified only after `phase_lock_i` has stayed high through LOCK_TICKS consecutive ticks. Any cycle with `phase_lock_i` low restarts that count from zero.
- R4: The controller returns to free-run if pre-locked has seen PRELOCK_TIMEOUT ticks without qualified lock. `new_ref_req_o` is high for exactly the one cycle in which the mode first reads free-run. Qualified lock takes priority over the timeout.
- R5: In locked, a low `phase_lock_i` moves the mode to lost-phase on the next clock.
- R6: In lost-phase, a high `bucket_disq_i` disqualifies the reference at once. `disq_o` pulses for one cycle. The new mode is pre-locked-2 if `standby_ok_i` is high, and holdover otherwise.
- R7: Once lost-phase has seen more than LOSTPHASE_TIMEOUT ticks, the reference is disqualified as in R6 and `phase_alarm_o` rises. The alarm stays high until the mode next becomes locked.
- R8: From lost-phase or pre-locked-2, qualified lock (R3) moves the mode to locked. In lost-phase, the bucket flag and the timeout both take priority over qualified lock.
- R9: `freeze_o` is high for exactly the one cycle in which the mode first reads holdover. This applies to every path into holdover, forced ones included.
- R10: In holdover, a `ref_sel_i` strobe moves the mode to pre-locked.
- R11: While `force_en_i` is high, `mode_o` takes `force_mode_i` on the next clock when the code is 0 to 5. Codes 6 and 7 leave the mode unchanged. No automatic transition, disqualify pulse or new-reference request happens while forced.
- R12: The tick timer behind R4 and R7 restarts on every mode change. A timeout therefore counts only ticks seen since the present mode was entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_sel_i | input | 1 | Strobe: a reference has been chosen |
| phase_lock_i | input | 1 | Loop phase-lock indicator |
| bucket_disq_i | input | 1 | Leaky-bucket anomaly flag requesting disqualification |
| standby_ok_i | input | 1 | A good standby reference is available |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| force_en_i | input | 1 | Forced control enable |
| force_mode_i | input | 3 | Mode code applied under forced control |
| mode_o | output | 3 | Current mode code |
| freeze_o | output | 1 | One-cycle pulse: hold the loop frequency |
| disq_o | output | 1 | One-cycle pulse: current reference disqualified |
| phase_alarm_o | output | 1 | Phase alarm after a lost-phase timeout |
| new_ref_req_o | output | 1 | One-cycle pulse: select another reference |

## Verification
Every result is registered. A mode change and the pulse that goes with it show up together, one clock after the edge that samples the cause. For tick-driven events, the tick's own edge updates the counters, and the transition comes one edge later. The bench therefore waits two idle cycles after each tick before it looks. A behavioural model is updated at each rising edge from the same inputs. Its outputs are compared with the design's 2 ns after that edge, while stimulus changes only on falling edges. On top of that compare, directed checks at the falling edge confirm each expected mode, and pulse counters confirm each expected strobe.

// File: rtl/clksync_pkg.sv
package clksync_pkg;
  typedef enum logic [2:0] {
    MODE_FREE = 3'd0,
    MODE_PRE  = 3'd1,
    MODE_LOCK = 3'd2,
    MODE_LOST = 3'd3,
    MODE_PRE2 = 3'd4,
    MODE_HOLD = 3'd5
  } mode_e;

  localparam logic [2:0] MODE_LAST = 3'd5;
endpackage

// File: rtl/clksync_lock_qual.sv
// Counts consecutive ticks with phase lock held; any gap restarts the count.
module clksync_lock_qual #(
  parameter int unsigned QUAL_TICKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_i,
  input  logic tick_i,
  output logic qualified_o
);
  localparam int unsigned CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] TOP = CW'(QUAL_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !lock_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qualified_o = lock_i && (cnt_q == TOP);
endmodule

// File: rtl/clksync_sec_timer.sv
// Saturating count of ticks since the last restart.
module clksync_sec_timer #(
  parameter int unsigned LIMIT = 101
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       restart_i,
  input  logic                       tick_i,
  output logic [$clog2(LIMIT+1)-1:0] count_o
);
  localparam int unsigned TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] SAT = TW'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      count_o <= '0;
    end else if (tick_i && count_o != SAT) begin
      count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/clksync_mode_ctrl.sv
module clksync_mode_ctrl
  import clksync_pkg::*;
#(
  parameter int unsigned LOCK_TICKS        = 1,
  parameter int unsigned PRELOCK_TIMEOUT   = 100,
  parameter int unsigned LOSTPHASE_TIMEOUT = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_sel_i,
  input  logic       phase_lock_i,
  input  logic       bucket_disq_i,
  input  logic       standby_ok_i,
  input  logic       sec_tick_i,
  input  logic       force_en_i,
  input  logic [2:0] force_mode_i,
  output logic [2:0] mode_o,
  output logic       freeze_o,
  output logic       disq_o,
  output logic       phase_alarm_o,
  output logic       new_ref_req_o
);
  localparam int unsigned TMR_MAX = (PRELOCK_TIMEOUT > LOSTPHASE_TIMEOUT + 1) ?
                                    PRELOCK_TIMEOUT : LOSTPHASE_TIMEOUT + 1;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

  mode_e            mode_q, mode_n;
  logic             qualified;
  logic [TMR_W-1:0] tmr;
  logic             mode_chg;
  logic             disq_n, req_n, alarm_set;
  logic             pre_expired, lost_expired;

  clksync_lock_qual #(.QUAL_TICKS(LOCK_TICKS)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .lock_i     (phase_lock_i),
    .tick_i     (sec_tick_i),
    .qualified_o(qualified)
  );

  clksync_sec_timer #(.LIMIT(TMR_MAX)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .restart_i(mode_chg),
    .tick_i   (sec_tick_i),
    .count_o  (tmr)
  );

  assign pre_expired  = 32'(tmr) >= PRELOCK_TIMEOUT;
  assign lost_expired = 32'(tmr) >  LOSTPHASE_TIMEOUT;
  assign mode_chg     = (mode_n != mode_q);

  always_comb begin
    mode_n    = mode_q;
    disq_n    = 1'b0;
    req_n     = 1'b0;
    alarm_set = 1'b0;
    if (force_en_i) begin
      if (force_mode_i <= MODE_LAST) mode_n = mode_e'(force_mode_i);
    end else begin
      case (mode_q)
        MODE_FREE: if (ref_sel_i) mode_n = MODE_PRE;
        MODE_PRE: begin
          if (qualified) begin
            mode_n = MODE_LOCK;
          end else if (pre_expired) begin
            mode_n = MODE_FREE;
            req_n  = 1'b1;
          end
        end
        MODE_LOCK: if (!phase_lock_i) mode_n = MODE_LOST;
        MODE_LOST: begin
          if (bucket_disq_i || lost_expired) begin
            disq_n    = 1'b1;
            alarm_set = !bucket_disq_i;
            mode_n    = standby_ok_i ? MODE_PRE2 : MODE_HOLD;
          end else if (qualified) begin
            mode_n = MODE_LOCK;
          end
        end
        MODE_PRE2: if (qualified) mode_n = MODE_LOCK;
        MODE_HOLD: if (ref_sel_i) mode_n = MODE_PRE;
        default:   mode_n = MODE_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q        <= MODE_FREE;
      freeze_o      <= 1'b0;
      disq_o        <= 1'b0;
      new_ref_req_o <= 1'b0;
      phase_alarm_o <= 1'b0;
    end else begin
      mode_q        <= mode_n;
      freeze_o      <= (mode_n == MODE_HOLD) && (mode_q != MODE_HOLD);
      disq_o        <= disq_n;
      new_ref_req_o <= req_n;
      if (alarm_set) begin
        phase_alarm_o <= 1'b1;
      end else if (mode_n == MODE_LOCK && mode_q != MODE_LOCK) begin
        phase_alarm_o <= 1'b0;
      end
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/clksync_mode_ctrl_chk.sv
module clksync_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       phase_lock_i,
  input logic       force_en_i,
  input logic [2:0] force_mode_i,
  input logic [2:0] mode_o,
  input logic       freeze_o,
  input logic       disq_o,
  input logic       phase_alarm_o,
  input logic       new_ref_req_o
);
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (rst)
    mode_o <= 3'd5);

  p_req_from_pre_r4: assert property (@(posedge clk) disable iff (rst)
    new_ref_req_o |-> (mode_o == 3'd0 && $past(mode_o) == 3'd1));

  p_lost_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (!force_en_i && mode_o == 3'd2 && !phase_lock_i) |=> (mode_o == 3'd3));

  p_disq_target_r6: assert property (@(posedge clk) disable iff (rst)
    disq_o |-> ((mode_o == 3'd4 || mode_o == 3'd5) && $past(mode_o) == 3'd3));

  p_alarm_with_disq_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_alarm_o) |-> disq_o);

  p_freeze_entry_r9: assert property (@(posedge clk) disable iff (rst)
    freeze_o |-> (mode_o == 3'd5 && $past(mode_o) != 3'd5));

  p_freeze_single_r9: assert property (@(posedge clk) disable iff (rst)
    freeze_o |=> !freeze_o);

  p_force_apply_r11: assert property (@(posedge clk) disable iff (rst)
    (force_en_i && force_mode_i <= 3'd5) |=> (mode_o == $past(force_mode_i)));

  p_force_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (force_en_i && force_mode_i > 3'd5) |=> $stable(mode_o));
endmodule

bind clksync_mode_ctrl clksync_mode_ctrl_chk u_chk (.*);

// File: tb/clksync_mode_ctrl_tb.sv
`timescale 1ns/1ps
module clksync_mode_ctrl_tb;
  localparam int LS  = 3;
  localparam int PTO = 8;
  localparam int LTO = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_sel = 0, pl = 0, bkt = 0, sby = 0, tick = 0, fe = 0;
  logic [2:0] fm = 3'd0;
  logic [2:0] mode;
  logic freeze, disq, alarm, req;

  int checks = 0, errors = 0;
  int n_req = 0, n_disq = 0, n_frz = 0;
  bit done = 0;
  string cur_tag = "R1";

  int m_mode = 0, m_lock = 0, m_tmr = 0;
  bit e_frz = 0, e_disq = 0, e_req = 0, m_alarm = 0;

  always #4 clk = ~clk;

  clksync_mode_ctrl #(.LOCK_TICKS(LS), .PRELOCK_TIMEOUT(PTO), .LOSTPHASE_TIMEOUT(LTO)) u_dut (
    .clk(clk), .rst(rst), .ref_sel_i(ref_sel), .phase_lock_i(pl), .bucket_disq_i(bkt),
    .standby_ok_i(sby), .sec_tick_i(tick), .force_en_i(fe), .force_mode_i(fm),
    .mode_o(mode), .freeze_o(freeze), .disq_o(disq), .phase_alarm_o(alarm),
    .new_ref_req_o(req));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk) begin
    bit lk, d, q, a;
    int nm;
    if (rst) begin
      m_mode = 0; m_lock = 0; m_tmr = 0; m_alarm = 0;
      e_frz = 0; e_disq = 0; e_req = 0;
    end else begin
      lk = pl && (m_lock >= LS);
      nm = m_mode; d = 0; q = 0; a = 0;
      if (fe) begin
        if (fm <= 5) nm = int'(fm);
      end else begin
        if (m_mode == 0 && ref_sel) nm = 1;
        else if (m_mode == 1) begin
          if (lk) nm = 2;
          else if (m_tmr >= PTO) begin nm = 0; q = 1; end
        end else if (m_mode == 2 && !pl) nm = 3;
        else if (m_mode == 3) begin
          if (bkt || m_tmr > LTO) begin
            d = 1; a = !bkt; nm = sby ? 4 : 5;
          end else if (lk) nm = 2;
        end else if (m_mode == 4 && lk) nm = 2;
        else if (m_mode == 5 && ref_sel) nm = 1;
      end
      e_frz = (nm == 5 && m_mode != 5);
      e_disq = d; e_req = q;
      if (a) m_alarm = 1;
      else if (nm == 2 && m_mode != 2) m_alarm = 0;
      if (!pl) m_lock = 0;
      else if (tick && m_lock < LS) m_lock++;
      if (nm != m_mode) m_tmr = 0;
      else if (tick) m_tmr++;
      m_mode = nm;
    end
  end

  // Per-cycle comparison, 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk(int'(mode) == m_mode, cur_tag, "mode_o", int'(mode), m_mode);
      chk(freeze == e_frz, cur_tag, "freeze_o", int'(freeze), int'(e_frz));
      chk(disq == e_disq, cur_tag, "disq_o", int'(disq), int'(e_disq));
      chk(req == e_req, cur_tag, "new_ref_req_o", int'(req), int'(e_req));
      chk(alarm == m_alarm, cur_tag, "phase_alarm_o", int'(alarm), int'(m_alarm));
      if (!rst) begin
        if (req) n_req++;
        if (disq) n_disq++;
        if (freeze) n_frz++;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_ref();
    ref_sel = 1; step(1); ref_sel = 0; step(1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; step(1); tick = 0; step(2);
    end
  endtask

  task automatic want_mode(input string tag, input int exp);
    chk(int'(mode) == exp, tag, "mode_o", int'(mode), exp);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int base;
    step(3);
    cur_tag = "R1";
    want_mode("R1", 0);
    chk(!freeze && !disq && !req && !alarm, "R1", "pulses after reset", 1, 0);
    rst = 0; step(2);
    want_mode("R1", 0);

    cur_tag = "R2";
    strobe_ref(); step(1);
    want_mode("R2", 1);

    cur_tag = "R4";
    base = n_req;
    ticks(PTO - 1);
    want_mode("R4", 1);
    ticks(1);
    want_mode("R4", 0);
    chk(n_req == base + 1, "R4", "request pulses", n_req - base, 1);

    cur_tag = "R3";
    strobe_ref(); step(1);
    pl = 1; ticks(2);
    pl = 0; step(1); pl = 1; step(1);
    ticks(2);
    want_mode("R3", 1);
    ticks(1);
    want_mode("R3", 2);

    cur_tag = "R5";
    pl = 0; step(2);
    want_mode("R5", 3);

    cur_tag = "R6";
    base = n_disq;
    sby = 1; bkt = 1; step(1); bkt = 0; step(1);
    want_mode("R6", 4);
    chk(n_disq == base + 1, "R6", "disq pulses", n_disq - base, 1);

    cur_tag = "R8";
    pl = 1; ticks(3);
    want_mode("R8", 2);

    cur_tag = "R9";
    pl = 0; step(2);
    base = n_frz;
    sby = 0; bkt = 1; step(1); bkt = 0; step(1);
    want_mode("R9", 5);
    chk(n_frz == base + 1, "R9", "freeze pulses", n_frz - base, 1);

    cur_tag = "R10";
    strobe_ref(); step(1);
    want_mode("R10", 1);

    cur_tag = "R7";
    pl = 1; ticks(3);
    want_mode("R7", 2);
    pl = 0; step(2);
    ticks(LTO);
    want_mode("R7", 3);
    chk(alarm == 0, "R7", "alarm early", int'(alarm), 0);
    ticks(1);
    want_mode("R7", 5);
    chk(alarm == 1, "R7", "alarm raised", int'(alarm), 1);
    strobe_ref(); pl = 1; ticks(3);
    want_mode("R7", 2);
    chk(alarm == 0, "R7", "alarm cleared on lock", int'(alarm), 0);

    cur_tag = "R8";
    pl = 0; step(2);
    want_mode("R8", 3);
    pl = 1; ticks(3);
    want_mode("R8", 2);

    cur_tag = "R11";
    base = n_frz;
    fe = 1; fm = 3'd5; step(2);
    want_mode("R11", 5);
    chk(n_frz == base + 1, "R11", "freeze on forced holdover", n_frz - base, 1);
    fm = 3'd7; step(3);
    want_mode("R11", 5);
    fm = 3'd2; step(2);
    want_mode("R11", 2);
    pl = 0; fm = 3'd6; step(3);
    want_mode("R11", 2);
    base = n_req;
    fm = 3'd1; ticks(PTO + 1);
    want_mode("R11", 1);
    chk(n_req == base, "R11", "no request under force", n_req - base, 0);
    fm = 3'd0; step(2);
    fe = 0; step(1);
    want_mode("R11", 0);

    cur_tag = "R12";
    ticks(PTO - 1);
    strobe_ref(); step(1);
    ticks(PTO - 1);
    want_mode("R12", 1);
    ticks(1);
    want_mode("R12", 0);

    step(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule